// File: doc/BRIEF.md
# Flash Command Register State Machine

This block models the device side of a byte-wide, bulk-erase flash part whose contents can only be changed through a command register. A host drives an address, a data byte and three active-low strobes (chip select, read gate and write strobe), plus two supply flags. One flag says the programming voltage is present and the other says the core supply is above its lockout level. The block decodes each completed write as a command, keeps the current mode, and runs whole-array erase and single-byte program pulses on a small on-chip array. Reads return array bytes, the two identifier bytes, or verify data.

Every change to the array needs a two-write sequence. Without programming voltage the block is a plain read-only memory. A pulse that the host fails to end is cut off by an internal stop timer, and the block then waits for a verify or reset command. The array is abstracted: a program pulse ANDs the written byte into the stored byte, and an erase pulse sets every byte to FFh. The pad driver is reduced to a registered output-enable flag.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the array holds FFh in every byte and the mode is read-array. While `vpp_hi` is low the mode is forced to read-array on every clock and all writes are ignored.
- R2: A write strobe exists only while `ce_n` and `we_n` are both low, `vcc_ok` is high and `vpp_hi` is high. The address is captured on the first clock of the strobe, the data byte on the last clock of the strobe, and the command takes effect on the first clock after the strobe ends.
- R3: Command 90h selects identifier reads. Address 0 returns 89h, address 1 returns the `DEV_CODE` parameter (default B4h), and any other address returns 00h.
- R4: Command 20h followed by a second 20h sets every array byte to FFh and starts an erase pulse.
- R5: Command A0h ends any pulse and keeps the address of its own strobe. Reads then return the byte at that kept address, whatever address is presented.
- R6: After command 40h, the next write whose data is not FFh programs its own address: the stored byte becomes old AND data, and a program pulse starts.
- R7: Command C0h ends any pulse. Reads then return the byte that was last programmed, whatever address is presented.
- R8: After 20h or 40h, two consecutive FFh writes abort the sequence, leave the array unchanged and restore read-array mode.
- R9: If `PULSE_LIMIT` clocks pass after a pulse starts with no write ending it, the block halts. While halted it reads the array, accepts only A0h, C0h and the FFh-FFh pair, and ignores every other write.
- R10: `out_en` and `dout` are registered. `out_en` is high one clock after a clock on which `ce_n` and `oe_n` were low and `we_n` was high.
- R11: A write of any code other than 00h, 90h, 20h, 40h, A0h, C0h leaves the read-array, identifier and verify modes unchanged. A write that ends a pulse with such a code returns to read-array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read gate, active low |
| we_n | input | 1 | Write strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| vcc_ok | input | 1 | Core supply above lockout |
| dout | output | 8 | Read data, registered |
| out_en | output | 1 | Output drive enable, registered |

## Verification
Read data and the output enable appear one clock after the address and strobes are sampled. A command takes effect on the clock that first sees the write strobe released, so any read that begins after that clock sees the new mode. The stop timer halts exactly `PULSE_LIMIT` clocks after the clock that started the pulse. The bench drives inputs on falling edges and samples on the falling edge after the rising edge that registers the result. Its behavioural model computes the expected values on each rising edge, and they are compared half a clock later, so both the model and the design are held to the same one-clock latency.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_READ  = 8'h00;
    localparam byte_t CMD_IDENT = 8'h90;
    localparam byte_t CMD_ERASE = 8'h20;
    localparam byte_t CMD_EVFY  = 8'hA0;
    localparam byte_t CMD_PROG  = 8'h40;
    localparam byte_t CMD_PVFY  = 8'hC0;
    localparam byte_t CMD_RESET = 8'hFF;
    localparam byte_t MFR_CODE  = 8'h89;
    localparam byte_t ERASED    = 8'hFF;

    typedef enum logic [3:0] {
        ST_READ,
        ST_ID,
        ST_ESETUP,
        ST_ERASING,
        ST_EVFY,
        ST_PSETUP,
        ST_PROGRAMMING,
        ST_PVFY,
        ST_ABORT1,
        ST_HALTED
    } mode_e;

    // Plain command decode; unknown codes keep the given fallback mode.
    function automatic mode_e decode_cmd(input mode_e fallback, input byte_t code);
        mode_e m;
        case (code)
            CMD_READ:  m = ST_READ;
            CMD_IDENT: m = ST_ID;
            CMD_ERASE: m = ST_ESETUP;
            CMD_PROG:  m = ST_PSETUP;
            CMD_EVFY:  m = ST_EVFY;
            CMD_PVFY:  m = ST_PVFY;
            default:   m = fallback;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flc_strobe.sv
module flc_strobe (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic vpp_hi,
    input  logic vcc_ok,
    output logic active,
    output logic begin_ev,
    output logic end_ev
);
    logic active_q;

    assign active   = !ce_n && !we_n && vcc_ok && vpp_hi;
    assign begin_ev = active && !active_q;
    assign end_ev   = !active && active_q;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end
endmodule

// File: rtl/flc_stop_timer.sv
module flc_stop_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && !start && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (start) cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flc_array.sv
module flc_array import flc_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill,
    input  logic              pgm,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  byte_t             pgm_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output byte_t             rd_a,
    output byte_t             rd_b
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (pgm) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    assign rd_a = mem[rd_addr_a];
    assign rd_b = mem[rd_addr_b];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flc_pkg::*; #(
    parameter int          ADDR_W      = 6,
    parameter logic [7:0]  DEV_CODE    = 8'hB4,
    parameter int          PULSE_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              vpp_hi,
    input  logic              vcc_ok,
    output logic [7:0]        dout,
    output logic              out_en
);
    logic wr_act, wr_begin, wr_end;
    logic fill, pgm, tstart, expired, set_vfy, pulse_run;
    mode_e state, nxt;
    logic [ADDR_W-1:0] addr_lat, vfy_addr, prog_addr, mark_addr;
    byte_t data_lat, arr_a, arr_b, rd_mux;

    flc_strobe u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .vpp_hi(vpp_hi), .vcc_ok(vcc_ok),
        .active(wr_act), .begin_ev(wr_begin), .end_ev(wr_end)
    );

    assign pulse_run = (state == ST_ERASING) || (state == ST_PROGRAMMING);

    flc_stop_timer #(.LIMIT(PULSE_LIMIT)) u_timer (
        .clk(clk), .rst(rst), .start(tstart), .run(pulse_run), .expired(expired)
    );

    // Address at strobe start, data held until strobe end.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lat  <= '0;
            data_lat  <= '0;
            vfy_addr  <= '0;
            prog_addr <= '0;
        end else begin
            if (wr_begin) addr_lat  <= addr;
            if (wr_act)   data_lat  <= din;
            if (set_vfy)  vfy_addr  <= addr_lat;
            if (pgm)      prog_addr <= addr_lat;
        end
    end

    always_comb begin
        nxt    = state;
        fill   = 1'b0;
        pgm    = 1'b0;
        tstart = 1'b0;
        if (!vpp_hi) begin
            nxt = ST_READ;
        end else if (wr_end) begin
            case (state)
                ST_ESETUP: begin
                    if (data_lat == CMD_ERASE) begin
                        nxt    = ST_ERASING;
                        fill   = 1'b1;
                        tstart = 1'b1;
                    end else if (data_lat == CMD_RESET) begin
                        nxt = ST_ABORT1;
                    end else begin
                        nxt = decode_cmd(state, data_lat);
                    end
                end
                ST_PSETUP: begin
                    if (data_lat == CMD_RESET) begin
                        nxt = ST_ABORT1;
                    end else begin
                        nxt    = ST_PROGRAMMING;
                        pgm    = 1'b1;
                        tstart = 1'b1;
                    end
                end
                ST_ABORT1:
                    nxt = (data_lat == CMD_RESET) ? ST_READ : decode_cmd(ST_READ, data_lat);
                ST_ERASING, ST_PROGRAMMING:
                    nxt = decode_cmd(ST_READ, data_lat);
                ST_HALTED: begin
                    case (data_lat)
                        CMD_EVFY:  nxt = ST_EVFY;
                        CMD_PVFY:  nxt = ST_PVFY;
                        CMD_RESET: nxt = ST_ABORT1;
                        default:   nxt = ST_HALTED;
                    endcase
                end
                default:
                    nxt = decode_cmd(state, data_lat);
            endcase
        end else if (expired) begin
            nxt = ST_HALTED;
        end
    end

    assign set_vfy = vpp_hi && wr_end && (nxt == ST_EVFY) && (data_lat == CMD_EVFY);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_READ;
        else     state <= nxt;
    end

    assign mark_addr = (state == ST_PVFY) ? prog_addr : vfy_addr;

    flc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .fill(fill), .pgm(pgm),
        .pgm_addr(addr_lat), .pgm_data(data_lat),
        .rd_addr_a(addr), .rd_addr_b(mark_addr),
        .rd_a(arr_a), .rd_b(arr_b)
    );

    always_comb begin
        case (state)
            ST_ID: begin
                if (addr == ADDR_W'(0))      rd_mux = MFR_CODE;
                else if (addr == ADDR_W'(1)) rd_mux = DEV_CODE;
                else                         rd_mux = 8'h00;
            end
            ST_EVFY, ST_PVFY: rd_mux = arr_b;
            default:          rd_mux = arr_a;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            out_en <= 1'b0;
        end else begin
            dout   <= rd_mux;
            out_en <= !ce_n && !oe_n && we_n;
        end
    end
endmodule

// File: rtl/flc_checker.sv
module flc_checker import flc_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input mode_e             state,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              out_en,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              vpp_hi,
    input logic              fill,
    input logic              pgm
);
    // R10
    out_en_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_en |-> $past(!ce_n && !oe_n && we_n));

    // R1
    vpp_low_read_chk: assert property (@(posedge clk) disable iff (rst)
        !vpp_hi |=> state == ST_READ);

    // R4
    erase_src_chk: assert property (@(posedge clk) disable iff (rst)
        fill |-> (state == ST_ESETUP && vpp_hi));

    // R6
    prog_src_chk: assert property (@(posedge clk) disable iff (rst)
        pgm |-> (state == ST_PSETUP && vpp_hi));

    // R9
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED && $past(state) != ST_HALTED) |->
        ($past(state) == ST_ERASING || $past(state) == ST_PROGRAMMING));

    // R3
    id_mfr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ID && addr == ADDR_W'(0)) |=> dout == MFR_CODE);
endmodule

bind flash_cmd_ctrl flc_checker #(.ADDR_W(ADDR_W)) u_flc_chk (
    .clk(clk), .rst(rst), .state(state), .addr(addr), .dout(dout),
    .out_en(out_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vpp_hi(vpp_hi), .fill(fill), .pgm(pgm)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
    localparam int AW = 6;
    localparam int LIM = 32;
    localparam int M_READ = 0, M_ID = 1, M_ES = 2, M_ER = 3, M_EV = 4,
                   M_PS = 5, M_PR = 6, M_PV = 7, M_AB = 8, M_HT = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic vpp_hi = 1'b1, vcc_ok = 1'b1;
    logic [7:0] dout;
    logic out_en;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .DEV_CODE(8'hB4), .PULSE_LIMIT(LIM)) u_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .vpp_hi(vpp_hi), .vcc_ok(vcc_ok), .dout(dout), .out_en(out_en)
    );

    // Behavioural reference model, evaluated on every rising edge.
    int m_mode;
    int m_tcnt;
    logic [7:0] m_mem [64];
    logic m_inw;
    logic [AW-1:0] m_alat, m_va, m_pa;
    logic [7:0] m_dlat;
    logic exp_oe;
    logic [7:0] exp_dout;
    string exp_tag;
    bit m_started = 0;

    function automatic int plain_cmd(input int fb, input logic [7:0] c);
        case (c)
            8'h00: return M_READ;
            8'h90: return M_ID;
            8'h20: return M_ES;
            8'h40: return M_PS;
            8'hA0: return M_EV;
            8'hC0: return M_PV;
            default: return fb;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [AW-1:0] a);
        if (m_mode == M_ID) return (a == 0) ? 8'h89 : (a == 1) ? 8'hB4 : 8'h00;
        if (m_mode == M_EV) return m_mem[m_va];
        if (m_mode == M_PV) return m_mem[m_pa];
        return m_mem[a];
    endfunction

    function automatic string mode_tag(input int md);
        if (md == M_ID) return "R3";
        if (md == M_EV) return "R5";
        if (md == M_PV) return "R7";
        if (md == M_HT) return "R9";
        return "R1";
    endfunction

    task automatic model_end(input logic [7:0] d);
        int nm;
        nm = m_mode;
        case (m_mode)
            M_ES: if (d == 8'h20) begin
                      nm = M_ER; m_tcnt = 0;
                      for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
                  end else if (d == 8'hFF) nm = M_AB;
                  else nm = plain_cmd(m_mode, d);
            M_PS: if (d == 8'hFF) nm = M_AB;
                  else begin
                      m_mem[m_alat] = m_mem[m_alat] & d;
                      m_pa = m_alat; nm = M_PR; m_tcnt = 0;
                  end
            M_AB: nm = (d == 8'hFF) ? M_READ : plain_cmd(M_READ, d);
            M_ER, M_PR: nm = plain_cmd(M_READ, d);
            M_HT: nm = (d == 8'hA0) ? M_EV : (d == 8'hC0) ? M_PV :
                       (d == 8'hFF) ? M_AB : M_HT;
            default: nm = plain_cmd(m_mode, d);
        endcase
        if (nm == M_EV && d == 8'hA0) m_va = m_alat;
        m_mode = nm;
    endtask

    always @(posedge clk) begin
        logic w;
        cycles++;
        if (rst) begin
            m_mode = M_READ; m_tcnt = 0; m_inw = 0;
            m_alat = '0; m_va = '0; m_pa = '0; m_dlat = '0;
            for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
            exp_oe = 0; exp_dout = 0; exp_tag = "R1";
        end else begin
            exp_oe = !ce_n && !oe_n && we_n;
            exp_dout = model_read(addr);
            exp_tag = mode_tag(m_mode);
            w = !ce_n && !we_n && vcc_ok && vpp_hi;
            if (w && !m_inw) m_alat = addr;
            if (w) m_dlat = din;
            if (!vpp_hi) m_mode = M_READ;
            else if (!w && m_inw) model_end(m_dlat);
            else if (m_mode == M_ER || m_mode == M_PR) begin
                m_tcnt++;
                if (m_tcnt == LIM) m_mode = M_HT;
            end
            m_inw = w;
        end
        m_started = 1;
    end

    // Per-clock comparison against the model (R10 for the enable).
    always @(negedge clk) begin
        if (m_started) begin
            checks++;
            if (out_en !== exp_oe) begin
                failures++;
                $display("FAIL R10 out_en actual=%0b expected=%0b t=%0t", out_en, exp_oe, $time);
            end
            if (exp_oe) begin
                checks++;
                if (dout !== exp_dout) begin
                    failures++;
                    $display("FAIL %s model dout actual=%02h expected=%02h t=%0t",
                             exp_tag, dout, exp_dout, $time);
                end
            end
        end
    end

    task automatic wr_ce(input logic [AW-1:0] a, input logic [7:0] d, input logic cen);
        @(negedge clk); addr = a; din = ~d; ce_n = cen; we_n = 1'b0;
        @(negedge clk); addr = ~a; din = d;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_ce(a, d, 1'b0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        checks++;
        if (dout !== exp || out_en !== 1'b1) begin
            failures++;
            $display("FAIL %s read a=%0d actual=%02h/%0b expected=%02h/1", tag, a, dout, out_en, exp);
        end
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_en !== 1'b0) begin
            failures++;
            $display("FAIL R10 out_en after release actual=%0b expected=0", out_en);
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(5, 8'hFF, "R1");
        // R6 / R7: program and verify
        wr(0, 8'h40); wr(5, 8'hA5); wr(0, 8'hC0); rd(9, 8'hA5, "R7");
        wr(0, 8'h00); rd(5, 8'hA5, "R6");
        wr(0, 8'h40); wr(5, 8'h3C); wr(0, 8'hC0); rd(0, 8'h24, "R7");
        wr(0, 8'h00); rd(5, 8'h24, "R6");
        // R3 identifier, R11 unknown code
        wr(0, 8'h90); rd(0, 8'h89, "R3"); rd(1, 8'hB4, "R3"); rd(2, 8'h00, "R3");
        wr(0, 8'h77); rd(0, 8'h89, "R11");
        wr(0, 8'h00); rd(0, 8'hFF, "R1");
        // R1 writes ignored with low programming voltage
        @(negedge clk); vpp_hi = 1'b0;
        wr(0, 8'h40); wr(5, 8'h00);
        @(negedge clk); vpp_hi = 1'b1;
        rd(5, 8'h24, "R1");
        // R2 lockout and chip select gating
        @(negedge clk); vcc_ok = 1'b0;
        wr(0, 8'h90);
        @(negedge clk); vcc_ok = 1'b1;
        rd(0, 8'hFF, "R2");
        wr_ce(0, 8'h90, 1'b1); rd(0, 8'hFF, "R2");
        // R8 aborts
        wr(0, 8'h40); wr(0, 8'hFF); wr(0, 8'hFF); rd(5, 8'h24, "R8");
        wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'hFF); rd(5, 8'h24, "R8");
        // R5 verify address latch
        wr(5, 8'hA0); rd(12, 8'h24, "R5");
        wr(0, 8'h40); wr(7, 8'h00); wr(0, 8'hC0); rd(0, 8'h00, "R7");
        // R4 erase
        wr(0, 8'h20); wr(0, 8'h20); wr(7, 8'hA0); rd(1, 8'hFF, "R5");
        wr(0, 8'h00); rd(7, 8'hFF, "R4"); rd(5, 8'hFF, "R4");
        // R9 stop timer on program
        wr(0, 8'h40); wr(6, 8'h0F);
        repeat (LIM + 8) @(negedge clk);
        wr(0, 8'h90); rd(0, 8'hFF, "R9");
        wr(0, 8'hC0); rd(2, 8'h0F, "R9");
        wr(0, 8'h00); rd(6, 8'h0F, "R6");
        // R9 stop timer on erase
        wr(0, 8'h20); wr(0, 8'h20);
        repeat (LIM + 8) @(negedge clk);
        wr(0, 8'h90); rd(0, 8'hFF, "R9");
        wr(0, 8'hFF); wr(0, 8'hFF); rd(6, 8'hFF, "R9");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule